// File: doc/BRIEF.md
# Serial Two's-Complement Negator

This block negates a binary integer that arrives one bit per clock, least significant bit first. The two's complement comes out in the same cycle as each input bit. The rule is simple. Every bit is copied up to and including the first 1 of the word, and every bit after that 1 is inverted. A single flag bit holds the only state: whether a 1 has appeared yet in the current word.

Words follow each other back to back. A start marker, sent together with the first bit of each word, clears the flag before that bit is evaluated. A qualifier strobe decides when a bit is present. On cycles where the strobe is low, the flag is held and the output has no meaning. The output is a Mealy function of the input and the flag, so it has no register delay.

Top module: `serial_negator`

## Requirements
- R1: After synchronous reset (`rst` high at a rising edge), the flag is clear, so a qualified 0 or 1 applied with no start marker is copied to `neg_bit`.
- R2: While the flag is clear, `neg_bit` equals `ser_bit` in the same cycle.
- R3: Once the flag is set, `neg_bit` equals the inverse of `ser_bit` in the same cycle.
- R4: The flag becomes set at the clock edge of a qualified cycle whose effective input bit is 1. It then stays set until a start marker or a reset.
- R5: A qualified cycle with `first` high treats the flag as clear for that bit, so the first bit of a word is always copied. The flag afterwards equals that bit.
- R6: Cycles with `bit_vld` low leave the flag unchanged. A later qualified bit is transformed just as it would have been without the idle cycles.
- R7: Over a whole word, the collected output bits equal the two's complement of the operand modulo 2^N. An all-zero operand comes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies ser_bit and first in this cycle |
| first | input | 1 | Marks the first (least significant) bit of a word |
| ser_bit | input | 1 | Serial operand bit, LSB first |
| neg_bit | output | 1 | Serial two's-complement bit, same cycle |

## Verification
Each `neg_bit` is due in the same cycle as its `ser_bit`. The flag change caused by a bit shows up only in the output for the next qualified bit. The bench drives inputs just after a falling edge, samples `neg_bit` combinationally before the next rising edge, and then lets that edge update the flag. This way every comparison lines up with the bit under test. The expected words come from arithmetic negation in the bench, not from a copy of the copy-then-invert rule.

// File: rtl/serial_negator_pkg.sv
package serial_negator_pkg;
  typedef enum logic {ST_COPY = 1'b0, ST_INVERT = 1'b1} neg_state_t;

  function automatic logic neg_out(input neg_state_t st, input logic b);
    return b ^ (st == ST_INVERT);
  endfunction

  function automatic neg_state_t neg_next(input neg_state_t st, input logic b);
    return (b || st == ST_INVERT) ? ST_INVERT : ST_COPY;
  endfunction
endpackage

// File: rtl/neg_state_reg.sv
module neg_state_reg
  import serial_negator_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  neg_state_t nxt,
  output neg_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst)      cur <= ST_COPY;
    else if (upd) cur <= nxt;
  end
endmodule

// File: rtl/neg_logic.sv
module neg_logic
  import serial_negator_pkg::*;
(
  input  neg_state_t cur,
  input  logic       start,
  input  logic       din,
  output neg_state_t eff,
  output neg_state_t nxt,
  output logic       dout
);
  always_comb begin
    eff  = start ? ST_COPY : cur;
    nxt  = neg_next(eff, din);
    dout = neg_out(eff, din);
  end
endmodule

// File: rtl/serial_negator.sv
module serial_negator
  import serial_negator_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic first,
  input  logic ser_bit,
  output logic neg_bit
);
  neg_state_t flag_q;
  neg_state_t flag_eff;
  neg_state_t flag_d;
  logic       start_qual;

  assign start_qual = bit_vld & first;

  neg_logic u_logic (
    .cur   (flag_q),
    .start (start_qual),
    .din   (ser_bit),
    .eff   (flag_eff),
    .nxt   (flag_d),
    .dout  (neg_bit)
  );

  neg_state_reg u_state (
    .clk (clk),
    .rst (rst),
    .upd (bit_vld),
    .nxt (flag_d),
    .cur (flag_q)
  );
endmodule

// File: rtl/serial_negator_chk.sv
module serial_negator_chk
  import serial_negator_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_vld,
  input logic       first,
  input logic       ser_bit,
  input logic       neg_bit,
  input neg_state_t flag_q
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> flag_q == ST_COPY);

  p_copy_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && (first || flag_q == ST_COPY)) |-> neg_bit == ser_bit);

  p_invert_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !first && flag_q == ST_INVERT) |-> neg_bit != ser_bit);

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !first && flag_q == ST_INVERT) |=> flag_q == ST_INVERT);

  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && ser_bit) |=> flag_q == ST_INVERT);

  p_start_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && first && !ser_bit) |=> flag_q == ST_COPY);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(flag_q));
endmodule

bind serial_negator serial_negator_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_vld (bit_vld),
  .first   (first),
  .ser_bit (ser_bit),
  .neg_bit (neg_bit),
  .flag_q  (flag_q)
);

// File: tb/tb_serial_negator.sv
`timescale 1ns/1ps
module tb_serial_negator;
  logic clk = 1'b0;
  logic rst, bit_vld, first, ser_bit;
  logic neg_bit;
  int   n_run = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  serial_negator dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld),
    .first(first), .ser_bit(ser_bit), .neg_bit(neg_bit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one qualified bit after negedge, sample before posedge
  task automatic send_bit(input logic st, input logic b, output logic o);
    @(negedge clk);
    bit_vld = 1'b1; first = st; ser_bit = b;
    #1 o = neg_bit;
    @(posedge clk);
    #0.1 bit_vld = 1'b0; first = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b0; ser_bit = $urandom_range(1);
      first = $urandom_range(1);
    end
    @(negedge clk); first = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input int gaps, input string req);
    logic [15:0] got;
    logic o;
    for (int i = 0; i < 16; i++) begin
      send_bit(i == 0, w[i], o);
      got[i] = o;
      if (gaps != 0 && i == 5) idle(gaps);
    end
    check(req, {16'h0, got}, {16'h0, 16'(-w)});
  endtask

  task automatic t_reset;
    logic o;
    @(negedge clk); rst = 1'b1; @(posedge clk); #0.1 rst = 1'b0;
    send_bit(1'b0, 1'b0, o); check("R1 zero after reset", o, 0);
    send_bit(1'b0, 1'b1, o); check("R1 one copied after reset", o, 1);
    send_bit(1'b0, 1'b1, o); check("R3 invert after first one", o, 0);
    send_bit(1'b0, 1'b0, o); check("R3 zero inverted", o, 1);
  endtask

  task automatic t_copy_zeros;
    logic o;
    send_bit(1'b1, 1'b0, o); check("R5 start clears flag", o, 0);
    send_bit(1'b0, 1'b0, o); check("R2 zero copied", o, 0);
    send_bit(1'b0, 1'b1, o); check("R2 first one copied", o, 1);
    send_bit(1'b0, 1'b1, o); check("R4 flag set sticks", o, 0);
  endtask

  task automatic t_idle_hold;
    logic o;
    send_bit(1'b1, 1'b1, o); check("R5 start bit one copied", o, 1);
    idle(4);
    send_bit(1'b0, 1'b1, o); check("R6 flag held across idle (set)", o, 0);
    send_bit(1'b1, 1'b0, o); check("R5 restart", o, 0);
    idle(3);
    send_bit(1'b0, 1'b0, o); check("R6 flag held across idle (clear)", o, 0);
  endtask

  initial begin
    rst = 1'b1; bit_vld = 1'b0; first = 1'b0; ser_bit = 1'b0;
    repeat (3) @(posedge clk);
    #0.1 rst = 1'b0;
    t_reset();
    t_copy_zeros();
    t_idle_hold();
    send_word(16'h0000, 0, "R7 zero word");
    send_word(16'h0001, 0, "R7 one");
    send_word(16'h8000, 0, "R7 msb only");
    send_word(16'hFFFF, 0, "R7 all ones");
    send_word(16'h1234, 2, "R7 with gaps R6");
    send_word(16'hA5A0, 0, "R7 back to back");
    for (int k = 0; k < 8; k++) send_word(16'($urandom), k % 3, "R7 random");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule